// File: doc/BRIEF.md
# Card Feed Cycle Sequencer

This block runs one card read cycle of a punched-card reader. A read order, with its stacking and chaining options, starts a feed cycle when the reader is idle, in automatic mode and has no interrupt outstanding. The block then turns the drive motors on and issues pick requests on a fixed retry schedule until the card reaches the read station. It then waits for end of card and reports the outcome to the host.

All timing is counted in ticks of a one-millisecond strobe input. The retry spacing, the feed timeout and the number of pick attempts are parameters. A missing card or a jam moves the block to a halted state: the motors stop, a feed-fault lamp output comes on and an unusual-end event is reported. Only an explicit operator reset leaves that state.

At end of card the block selects a stacker and reports channel end. It then does one of three things: it starts the next feed at once if another order is already waiting, it asks for a new order when chaining is set, or it returns to idle with an interrupt pending for the host.

Top module: `card_feed_seq`

## Requirements
- R1: After reset the block is idle (`rdy`=1, `busy`=0, `not_oper`=0, motor off, no fault, nothing pending). From idle, an `order_vld` strobe starts a feed only if `auto_mode`=1 and `int_pending`=0. A started feed shows `busy`=1, `motor_en`=1 and a one-cycle `pick_req` pulse in the cycle after the strobe.
- R2: While the card has not arrived, `pick_req` pulses again on every RETRY_MS-th millisecond tick after the start, for at most MAX_PICKS pulses in total (3 by default, at ticks 0, 32 and 64).
- R3: If the TIMEOUT_MS-th tick (96 by default) arrives before the card reaches the read station, the block enters the halted state in the cycle after that tick. In that state `not_oper`=1, `feed_fault`=1 and `motor_en`=0, a one-cycle `unusual_end` pulse is issued and `int_pending` is set.
- R4: A `jam` input while feeding or reading causes the same halt, fault lamp, motor stop and `unusual_end` pulse as R3.
- R5: An `end_of_card` while reading gives a one-cycle `chan_end` pulse in the next cycle. If the order was not chained and no further order is waiting, the block goes to idle with `int_pending`=1.
- R6: If the current order had chaining set (`order_chain`=1) and no further order is waiting, `chan_end` is accompanied by a one-cycle `new_order_req` pulse, `int_pending` stays 0 and the block goes to idle.
- R7: An order strobed while busy is held as a waiting order, with its own options. At end of card with `auto_mode`=1, a new feed starts at once: `busy` stays 1 and `pick_req` pulses together with `chan_end`. With `auto_mode`=0 at end of card, the waiting order is dropped and the block goes idle.
- R8: In the same cycle as `chan_end`, exactly one of `stack_alt` and `stack_norm` pulses. `stack_alt` is chosen when the order had `order_alt`=1, or when it had `order_soe`=1 and `data_err` was seen during the cycle. Otherwise `stack_norm` is chosen.
- R9: The halted state is left only by `op_reset`, which returns the block to idle and clears `feed_fault` and `int_pending`. In the halted state, orders and `host_ack` do not restart the reader.
- R10: `host_ack` clears `int_pending`. While `int_pending`=1 in idle, order strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_vld | input | 1 | Read-order strobe |
| order_alt | input | 1 | Order option: alternate stacker |
| order_soe | input | 1 | Order option: alternate stacker on error |
| order_chain | input | 1 | Order option: command chaining |
| auto_mode | input | 1 | Reader is in automatic mode |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| card_at_station | input | 1 | Card leading edge at the read station |
| end_of_card | input | 1 | Card trailing edge has passed |
| jam | input | 1 | Transport fault sensor |
| data_err | input | 1 | Error flagged on the current card |
| host_ack | input | 1 | Host acknowledges the pending interrupt |
| op_reset | input | 1 | Operator reset out of the halted state |
| pick_req | output | 1 | One-cycle pick attempt pulse |
| motor_en | output | 1 | Drive motor enable |
| feed_fault | output | 1 | Feed-fault indicator |
| stack_norm | output | 1 | Pulse: route card to normal stacker |
| stack_alt | output | 1 | Pulse: route card to alternate stacker |
| chan_end | output | 1 | Channel-end pulse |
| unusual_end | output | 1 | Unusual-end pulse |
| new_order_req | output | 1 | Pulse: chaining asks for the next order |
| int_pending | output | 1 | Interrupt pending until acknowledged |
| rdy | output | 1 | Idle and ready state |
| busy | output | 1 | Feeding or reading |
| not_oper | output | 1 | Halted, not operational |

## Verification
Every result of this block comes from a register, so each one appears one clock after the edge that samples its cause. This holds for the pick pulse after an order strobe or a retry tick, for the halt after the timeout tick or a jam, and for channel end, stacker select and the chain request after end of card. The bench drives each stimulus at a falling edge and samples at the next falling edge, which is exactly one rising edge later. It checks pulses in that cycle and again one cycle later to confirm they have dropped. Ticks are issued one at a time with an idle cycle between them, so the bench can count pick pulses tick by tick and expect the halt right after tick 96.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FEED = 2'd1,
      ST_READ = 2'd2,
      ST_HALT = 2'd3
   } feed_state_e;

   typedef struct packed {
      logic alt;
      logic soe;
      logic chain;
   } order_opt_t;

endpackage

// File: rtl/cfs_feed_timer.sv
module cfs_feed_timer #(
   parameter int RETRY_MS   = 32,
   parameter int TIMEOUT_MS = 96,
   parameter int MAX_PICKS  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic ms_tick,
   output logic retry_hit,
   output logic timeout_hit
);
   localparam int EW = $clog2(TIMEOUT_MS + 1);
   localparam int RW = $clog2(RETRY_MS + 1);
   localparam int PW = $clog2(MAX_PICKS + 1);

   logic [EW-1:0] elapsed;
   logic [RW-1:0] gap;
   logic [PW-1:0] picks;
   logic          step_en;
   logic          gap_end;

   assign step_en     = active && ms_tick;
   assign gap_end     = (gap == RW'(RETRY_MS - 1));
   assign retry_hit   = step_en && gap_end && (picks < PW'(MAX_PICKS));
   assign timeout_hit = step_en && (elapsed == EW'(TIMEOUT_MS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= '0;
         gap     <= '0;
         picks   <= '0;
      end else if (start) begin
         elapsed <= '0;
         gap     <= '0;
         picks   <= PW'(1);
      end else if (step_en) begin
         if (elapsed != EW'(TIMEOUT_MS))
            elapsed <= elapsed + EW'(1);
         gap <= gap_end ? '0 : gap + RW'(1);
         if (retry_hit)
            picks <= picks + PW'(1);
      end
   end
endmodule

// File: rtl/cfs_order_latch.sv
module cfs_order_latch
   import cfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  order_opt_t order_in,
   input  logic       order_vld,
   input  logic       busy,
   input  logic       take_idle,
   input  logic       take_next,
   input  logic       flush,
   output order_opt_t cur,
   output logic       next_avail
);
   order_opt_t nxt;
   logic       nxt_vld;

   assign next_avail = nxt_vld || order_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (take_idle) begin
         cur <= order_in;
      end else if (take_next) begin
         cur <= nxt_vld ? nxt : order_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt     <= '0;
         nxt_vld <= 1'b0;
      end else if (take_next || flush) begin
         nxt_vld <= 1'b0;
      end else if (busy && order_vld && !nxt_vld) begin
         nxt     <= order_in;
         nxt_vld <= 1'b1;
      end
   end
endmodule

// File: rtl/cfs_stacker.sv
module cfs_stacker #(
   parameter bit SOE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   input  logic data_err,
   input  logic card_done,
   input  logic want_alt,
   input  logic want_soe,
   output logic stack_norm,
   output logic stack_alt
);
   logic err_seen;
   logic go_alt;

   generate
      if (SOE_EN) begin : g_soe
         assign go_alt = want_alt || (want_soe && (err_seen || data_err));
      end else begin : g_no_soe
         assign go_alt = want_alt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_seen <= 1'b0;
      end else if (start) begin
         err_seen <= 1'b0;
      end else if (busy && data_err) begin
         err_seen <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stack_norm <= 1'b0;
         stack_alt  <= 1'b0;
      end else begin
         stack_norm <= card_done && !go_alt;
         stack_alt  <= card_done && go_alt;
      end
   end
endmodule

// File: rtl/card_feed_seq.sv
module card_feed_seq
   import cfs_pkg::*;
#(
   parameter int RETRY_MS   = 32,
   parameter int TIMEOUT_MS = 96,
   parameter int MAX_PICKS  = 3,
   parameter bit SOE_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic order_vld,
   input  logic order_alt,
   input  logic order_soe,
   input  logic order_chain,
   input  logic auto_mode,
   input  logic ms_tick,
   input  logic card_at_station,
   input  logic end_of_card,
   input  logic jam,
   input  logic data_err,
   input  logic host_ack,
   input  logic op_reset,
   output logic pick_req,
   output logic motor_en,
   output logic feed_fault,
   output logic stack_norm,
   output logic stack_alt,
   output logic chan_end,
   output logic unusual_end,
   output logic new_order_req,
   output logic int_pending,
   output logic rdy,
   output logic busy,
   output logic not_oper
);

   generate
      if (RETRY_MS < 1) begin : g_bad_retry
         $error("card_feed_seq: RETRY_MS must be at least 1");
      end
      if (MAX_PICKS < 1) begin : g_bad_picks
         $error("card_feed_seq: MAX_PICKS must be at least 1");
      end
      if (TIMEOUT_MS <= (MAX_PICKS - 1) * RETRY_MS) begin : g_bad_timeout
         $error("card_feed_seq: TIMEOUT_MS must exceed the last pick time");
      end
   endgenerate

   feed_state_e state_q, state_d;
   order_opt_t  order_in;
   order_opt_t  cur;
   logic        next_avail;
   logic        in_feed, in_read, busy_s;
   logic        accept_idle, card_done, back2back, start, fault;
   logic        retry_hit, timeout_hit;
   logic        pick_q, chan_q, unus_q, newreq_q, pend_q, fault_q;

   assign order_in    = '{alt: order_alt, soe: order_soe, chain: order_chain};
   assign in_feed     = (state_q == ST_FEED);
   assign in_read     = (state_q == ST_READ);
   assign busy_s      = in_feed || in_read;

   assign accept_idle = (state_q == ST_IDLE) && order_vld && auto_mode && !pend_q;
   assign fault       = (in_feed && (timeout_hit || jam)) || (in_read && jam);
   assign card_done   = in_read && end_of_card && !jam;
   assign back2back   = card_done && next_avail && auto_mode;
   assign start       = accept_idle || back2back;

   cfs_feed_timer #(
      .RETRY_MS  (RETRY_MS),
      .TIMEOUT_MS(TIMEOUT_MS),
      .MAX_PICKS (MAX_PICKS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .active     (in_feed),
      .ms_tick    (ms_tick),
      .retry_hit  (retry_hit),
      .timeout_hit(timeout_hit)
   );

   cfs_order_latch u_orders (
      .clk       (clk),
      .rst_n     (rst_n),
      .order_in  (order_in),
      .order_vld (order_vld),
      .busy      (busy_s),
      .take_idle (accept_idle),
      .take_next (back2back),
      .flush     (fault || card_done),
      .cur       (cur),
      .next_avail(next_avail)
   );

   cfs_stacker #(
      .SOE_EN(SOE_EN)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .busy      (busy_s),
      .data_err  (data_err),
      .card_done (card_done),
      .want_alt  (cur.alt),
      .want_soe  (cur.soe),
      .stack_norm(stack_norm),
      .stack_alt (stack_alt)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept_idle) state_d = ST_FEED;
         ST_FEED: begin
            if (fault)                state_d = ST_HALT;
            else if (card_at_station) state_d = ST_READ;
         end
         ST_READ: begin
            if (fault)          state_d = ST_HALT;
            else if (card_done) state_d = back2back ? ST_FEED : ST_IDLE;
         end
         ST_HALT: if (op_reset) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pick_q   <= 1'b0;
         chan_q   <= 1'b0;
         unus_q   <= 1'b0;
         newreq_q <= 1'b0;
      end else begin
         pick_q   <= start ||
                     (in_feed && !fault && !card_at_station && retry_hit);
         chan_q   <= card_done;
         unus_q   <= fault;
         newreq_q <= card_done && !back2back && cur.chain;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (fault || (card_done && !back2back && !cur.chain)) begin
         pend_q <= 1'b1;
      end else if (host_ack || ((state_q == ST_HALT) && op_reset)) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else if (fault) begin
         fault_q <= 1'b1;
      end else if ((state_q == ST_HALT) && op_reset) begin
         fault_q <= 1'b0;
      end
   end

   assign pick_req      = pick_q;
   assign chan_end      = chan_q;
   assign unusual_end   = unus_q;
   assign new_order_req = newreq_q;
   assign int_pending   = pend_q;
   assign feed_fault    = fault_q;
   assign motor_en      = busy_s;
   assign busy          = busy_s;
   assign rdy           = (state_q == ST_IDLE);
   assign not_oper      = (state_q == ST_HALT);

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker (
   input logic clk,
   input logic rst_n,
   input logic order_vld,
   input logic auto_mode,
   input logic op_reset,
   input logic pick_req,
   input logic motor_en,
   input logic feed_fault,
   input logic stack_norm,
   input logic stack_alt,
   input logic chan_end,
   input logic unusual_end,
   input logic new_order_req,
   input logic int_pending,
   input logic rdy,
   input logic busy,
   input logic not_oper
);
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(motor_en) |-> ($past(order_vld) && $past(auto_mode))); // R1
   AST_PICK_WITH_MOTOR: assert property (@(posedge clk) disable iff (!rst_n)
      pick_req |-> motor_en); // R2
   AST_HALT_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      not_oper |-> (!motor_en && feed_fault)); // R3
   AST_UNUSUAL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      unusual_end |-> not_oper); // R4
   AST_CHAN_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_end |=> !chan_end); // R5
   AST_CHAIN_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
      new_order_req |-> (chan_end && !int_pending)); // R6
   AST_STACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stack_alt, stack_norm})); // R8
   AST_STACK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (stack_alt || stack_norm) |-> chan_end); // R8
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (not_oper && !op_reset) |=> not_oper); // R9
   AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({rdy, busy, not_oper})); // R9
   AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && int_pending) |=> !motor_en); // R10
endmodule

bind card_feed_seq cfs_checker u_cfs_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .order_vld    (order_vld),
   .auto_mode    (auto_mode),
   .op_reset     (op_reset),
   .pick_req     (pick_req),
   .motor_en     (motor_en),
   .feed_fault   (feed_fault),
   .stack_norm   (stack_norm),
   .stack_alt    (stack_alt),
   .chan_end     (chan_end),
   .unusual_end  (unusual_end),
   .new_order_req(new_order_req),
   .int_pending  (int_pending),
   .rdy          (rdy),
   .busy         (busy),
   .not_oper     (not_oper)
);

// File: tb/card_feed_seq_bench.sv
module card_feed_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic order_vld = 0, order_alt = 0, order_soe = 0, order_chain = 0;
   logic auto_mode = 1, ms_tick = 0, card_at_station = 0, end_of_card = 0;
   logic jam = 0, data_err = 0, host_ack = 0, op_reset = 0;
   logic pick_req, motor_en, feed_fault, stack_norm, stack_alt, chan_end;
   logic unusual_end, new_order_req, int_pending, rdy, busy, not_oper;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   card_feed_seq u_card_feed_seq (.*);

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic issue_order(input bit alt, input bit soe, input bit chain);
      order_alt = alt; order_soe = soe; order_chain = chain; order_vld = 1;
      step();
      order_vld = 0; order_alt = 0; order_soe = 0; order_chain = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         ms_tick = 1; step(); ms_tick = 0; step();
      end
   endtask

   task automatic card_in();
      card_at_station = 1; step(); card_at_station = 0;
   endtask

   task automatic card_out();
      end_of_card = 1; step(); end_of_card = 0;
   endtask

   task automatic ack();
      host_ack = 1; step(); host_ack = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset rdy", rdy, 1);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset motor", motor_en, 0);
      chk("R1 reset not_oper", not_oper, 0);
      chk("R1 reset fault", feed_fault, 0);
      chk("R1 reset pending", int_pending, 0);
   endtask

   task automatic t_normal();
      issue_order(0, 0, 0);
      chk("R1 pick after order", pick_req, 1);
      chk("R1 busy after order", busy, 1);
      chk("R1 motor on", motor_en, 1);
      step();
      chk("R1 pick one cycle", pick_req, 0);
      ticks(5);
      card_in();
      chk("R5 reading busy", busy, 1);
      card_out();
      chk("R5 chan_end", chan_end, 1);
      chk("R8 normal stacker", stack_norm, 1);
      chk("R8 no alt", stack_alt, 0);
      chk("R5 back to idle", rdy, 1);
      chk("R5 pending set", int_pending, 1);
      chk("R6 no chain req", new_order_req, 0);
      step();
      chk("R5 chan_end one cycle", chan_end, 0);
      issue_order(0, 0, 0);
      chk("R10 order ignored while pending", busy, 0);
      chk("R10 no pick while pending", pick_req, 0);
      ack();
      chk("R10 ack clears pending", int_pending, 0);
   endtask

   task automatic t_manual();
      auto_mode = 0;
      issue_order(0, 0, 0);
      chk("R1 manual mode ignores order", busy, 0);
      chk("R1 manual mode no pick", pick_req, 0);
      auto_mode = 1;
   endtask

   task automatic t_timeout();
      int picks;
      issue_order(0, 0, 0);
      picks = pick_req ? 1 : 0;
      for (int i = 1; i < 96; i++) begin
         ms_tick = 1; step();
         if (pick_req) picks++;
         if (i == 32) chk("R2 retry at tick 32", pick_req, 1);
         ms_tick = 0; step();
         if (pick_req) picks++;
      end
      chk("R2 pick count", picks, 3);
      chk("R3 still feeding before limit", busy, 1);
      ms_tick = 1; step(); ms_tick = 0;
      chk("R3 halted", not_oper, 1);
      chk("R3 fault lamp", feed_fault, 1);
      chk("R3 motor off", motor_en, 0);
      chk("R3 unusual_end", unusual_end, 1);
      chk("R3 pending", int_pending, 1);
      step();
      chk("R3 unusual one cycle", unusual_end, 0);
      issue_order(0, 0, 0);
      chk("R9 order ignored halted", not_oper, 1);
      ack();
      chk("R9 ack does not restart", not_oper, 1);
      op_reset = 1; step(); op_reset = 0;
      chk("R9 op_reset to idle", rdy, 1);
      chk("R9 fault cleared", feed_fault, 0);
      chk("R9 pending cleared", int_pending, 0);
   endtask

   task automatic t_jam();
      issue_order(0, 0, 0);
      ticks(2);
      card_in();
      jam = 1; step(); jam = 0;
      chk("R4 jam halts", not_oper, 1);
      chk("R4 jam unusual_end", unusual_end, 1);
      chk("R4 jam motor off", motor_en, 0);
      chk("R4 jam fault lamp", feed_fault, 1);
      op_reset = 1; step(); op_reset = 0;
      chk("R9 recovered after jam", rdy, 1);
   endtask

   task automatic t_chain();
      issue_order(0, 0, 1);
      ticks(3);
      card_in();
      card_out();
      chk("R6 chan_end", chan_end, 1);
      chk("R6 new order request", new_order_req, 1);
      chk("R6 no pending", int_pending, 0);
      chk("R6 idle", rdy, 1);
      step();
      chk("R6 request one cycle", new_order_req, 0);
   endtask

   task automatic t_stack();
      issue_order(0, 1, 0);
      card_in();
      data_err = 1; step(); data_err = 0;
      card_out();
      chk("R8 soe with error alt", stack_alt, 1);
      chk("R8 soe with error not norm", stack_norm, 0);
      ack();
      issue_order(0, 1, 0);
      card_in();
      card_out();
      chk("R8 soe clean norm", stack_norm, 1);
      chk("R8 soe clean not alt", stack_alt, 0);
      ack();
      issue_order(1, 0, 0);
      card_in();
      card_out();
      chk("R8 alt order alt", stack_alt, 1);
      ack();
   endtask

   task automatic t_b2b();
      issue_order(0, 0, 0);
      card_in();
      issue_order(1, 0, 0);
      chk("R7 order latched, still busy", busy, 1);
      chk("R7 no pick on latch", pick_req, 0);
      card_out();
      chk("R7 chan_end", chan_end, 1);
      chk("R7 immediate pick", pick_req, 1);
      chk("R7 stays busy", busy, 1);
      chk("R7 no pending", int_pending, 0);
      chk("R8 first card norm", stack_norm, 1);
      step();
      card_in();
      card_out();
      chk("R7 second card options kept", stack_alt, 1);
      chk("R7 second end pending", int_pending, 1);
      ack();
      issue_order(0, 0, 0);
      card_in();
      issue_order(0, 0, 0);
      auto_mode = 0;
      card_out();
      chk("R7 manual at end idles", rdy, 1);
      chk("R7 manual at end no pick", pick_req, 0);
      auto_mode = 1;
      ack();
      step();
      chk("R7 waiting order dropped", busy, 0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_normal();
      t_manual();
      t_timeout();
      t_jam();
      t_chain();
      t_stack();
      t_b2b();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule